// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block produces two independently programmed clock outputs meant for external pins. Each output picks one of five source clocks and divides it by a power of two, from 1 to 64. The sources are modelled as single-cycle enable strobes in the block's own clock domain. Each output is likewise a single-cycle strobe, one per divided period. Real glitch-free multiplexing and analog sources lie outside the block.

Software sets up an output through a configuration write that carries an output index, a source code and a prescaler exponent. It switches the output on by pulsing its bit on the set port and off by pulsing its bit on the clear port. An active mask reports which outputs are switched on. A ready mask reports, per output, that the output has produced at least one divided edge with the settings now stored. Changing the settings while an output runs is allowed but unprotected. The running count is not restarted, so the period in which the change lands is irregular. Settings should therefore be changed only while the output is off. There is no data stream, so every pin is a plain control or status signal with no valid/ready handshake or back-pressure.

Top module: `clkout_gen`

## Requirements
- R1: After reset, `out_active`, `out_ready` and `out_tick` are all zero, and every output reads back source code 0 (slow) and prescaler code 0 (divide by 1).
- R2: A 1 in bit i of `en_set` makes `out_active[i]` 1 from the next cycle on. A 0 bit leaves that output's state unchanged.
- R3: A 1 in bit i of `en_clr` makes `out_active[i]` 0 from the next cycle on. When the same bit is 1 on both `en_set` and `en_clr` in one cycle, the clear wins.
- R4: Source code values map to `src_tick` bits as follows: 0 = slow (bit 0), 1 = main (bit 1), 2 = PLL A (bit 2), 3 = USB PLL (bit 3), 4 = master (bit 4). An output counts only strobes on the bit its code selects.
- R5: With prescaler code n (0 to 6), an active output emits one `out_tick` pulse for every 2^n selected strobes. The pulse appears in the cycle after the completing strobe, and the first pulse after enabling follows the 2^n-th strobe.
- R6: Prescaler code 7 reads back as 7 and divides like code 6, by 64.
- R7: Source codes 5, 6 and 7 select no strobe, so the output never pulses and its ready bit stays 0.
- R8: `out_ready[i]` becomes 1 in the same cycle as the first pulse after enabling. It drops to 0 in the cycle after a configuration write to output i, and in the cycle after a clear of output i.
- R9: A configuration write to an active output keeps it active and does not restart its count. If the count already reached the new terminal value, the next selected strobe completes a period.
- R10: A configuration write with `cfg_idx` = i changes only output i's readback, ready bit and division. The other output is unaffected.
- R11: An inactive output emits no pulses, and its count restarts from zero when it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all source strobes are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | NUM_SRC | Source strobes: bit 0 slow, 1 main, 2 PLL A, 3 USB PLL, 4 master |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Output addressed by the configuration write |
| cfg_src | input | 3 | Source code to store |
| cfg_pres | input | 3 | Prescaler exponent to store |
| en_set | input | NUM_OUT | Write-one-to-enable mask |
| en_clr | input | NUM_OUT | Write-one-to-disable mask |
| cfg_src_q | output | NUM_OUT*3 | Stored source codes, output i at bits [3i+2:3i] |
| cfg_pres_q | output | NUM_OUT*3 | Stored prescaler codes, output i at bits [3i+2:3i] |
| out_active | output | NUM_OUT | Per-output enable status |
| out_ready | output | NUM_OUT | Per-output ready flag |
| out_tick | output | NUM_OUT | Divided output strobes |

## Verification
The bench builds the block with its defaults: two outputs, five sources and a largest exponent of 6. That makes the full divide-by-64 range reachable, along with the saturation of code 7 onto it, within a few hundred strobes. Two outputs are enough to show that a write aimed at one output leaves the other untouched, and to drive sources that one output ignores while the other counts them. Directed sequences also reach mid-count configuration changes, same-cycle set and clear, and a disable in the middle of a period followed by a restart.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  localparam int SRC_W  = 3;
  localparam int PRES_W = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_SLOW   = 3'd0,
    SRC_MAIN   = 3'd1,
    SRC_PLLA   = 3'd2,
    SRC_USB    = 3'd3,
    SRC_MASTER = 3'd4
  } src_code_e;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [PRES_W-1:0] pres;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RESET = '{src: SRC_SLOW, pres: '0};

endpackage

// File: rtl/clkout_ctrl.sv
module clkout_ctrl #(
  parameter int NUM_OUT = 2,
  parameter int IDX_W   = 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [IDX_W-1:0]                      cfg_idx,
  input  logic [clkout_pkg::SRC_W-1:0]          cfg_src,
  input  logic [clkout_pkg::PRES_W-1:0]         cfg_pres,
  input  logic [NUM_OUT-1:0]                    en_set,
  input  logic [NUM_OUT-1:0]                    en_clr,
  output clkout_pkg::chan_cfg_t [NUM_OUT-1:0]   cfg_q,
  output logic [NUM_OUT-1:0]                    active,
  output logic [NUM_OUT-1:0]                    cfg_hit
);
  import clkout_pkg::*;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_reg
    assign cfg_hit[i] = cfg_we && (cfg_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[i]  <= CFG_RESET;
        active[i] <= 1'b0;
      end else begin
        if (cfg_hit[i]) begin
          cfg_q[i].src  <= cfg_src;
          cfg_q[i].pres <= cfg_pres;
        end
        // clear has priority over set
        if (en_clr[i])      active[i] <= 1'b0;
        else if (en_set[i]) active[i] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/clkout_srcmux.sv
module clkout_srcmux #(
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0]              src_tick,
  input  logic [clkout_pkg::SRC_W-1:0]    sel,
  output logic                            sel_tick
);
  localparam int SEL_SPAN = 1 << clkout_pkg::SRC_W;

  logic [SEL_SPAN-1:0] padded;

  // codes beyond the last source land on constant zeros
  for (genvar s = 0; s < SEL_SPAN; s++) begin : g_pad
    if (s < NUM_SRC) begin : g_src
      assign padded[s] = src_tick[s];
    end else begin : g_none
      assign padded[s] = 1'b0;
    end
  end

  assign sel_tick = padded[sel];

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider #(
  parameter int MAX_EXP = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          active,
  input  logic                          sel_tick,
  input  logic                          kill,
  input  logic [clkout_pkg::PRES_W-1:0] pres,
  output logic                          tick,
  output logic                          ready
);
  localparam int CNT_W = (MAX_EXP < 1) ? 1 : MAX_EXP;

  logic [clkout_pkg::PRES_W-1:0] exp_eff;
  logic [CNT_W:0]                lim_wide;
  logic [CNT_W-1:0]              lim;
  logic [CNT_W-1:0]              cnt;
  logic                          done;

  // codes above the largest exponent saturate onto it
  assign exp_eff  = (int'(pres) > MAX_EXP) ? clkout_pkg::PRES_W'(MAX_EXP) : pres;
  assign lim_wide = ((CNT_W+1)'(1) << exp_eff) - (CNT_W+1)'(1);
  assign lim      = lim_wide[CNT_W-1:0];
  // >= so that a limit lowered mid-count cannot strand the counter
  assign done     = active && sel_tick && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      tick  <= 1'b0;
      ready <= 1'b0;
    end else begin
      tick <= done;
      if (!active)       cnt <= '0;
      else if (done)     cnt <= '0;
      else if (sel_tick) cnt <= cnt + 1'b1;
      if (kill)          ready <= 1'b0;
      else if (done)     ready <= 1'b1;
    end
  end

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen #(
  parameter int NUM_OUT = 2,
  parameter int NUM_SRC = 5,
  parameter int MAX_EXP = 6,
  localparam int IDX_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int SRC_W  = clkout_pkg::SRC_W,
  localparam int PRES_W = clkout_pkg::PRES_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          src_tick,
  input  logic                        cfg_we,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [SRC_W-1:0]            cfg_src,
  input  logic [PRES_W-1:0]           cfg_pres,
  input  logic [NUM_OUT-1:0]          en_set,
  input  logic [NUM_OUT-1:0]          en_clr,
  output logic [NUM_OUT*SRC_W-1:0]    cfg_src_q,
  output logic [NUM_OUT*PRES_W-1:0]   cfg_pres_q,
  output logic [NUM_OUT-1:0]          out_active,
  output logic [NUM_OUT-1:0]          out_ready,
  output logic [NUM_OUT-1:0]          out_tick
);
  import clkout_pkg::*;

  chan_cfg_t [NUM_OUT-1:0] cfg_q;
  logic [NUM_OUT-1:0]      cfg_hit;

  clkout_ctrl #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_src  (cfg_src),
    .cfg_pres (cfg_pres),
    .en_set   (en_set),
    .en_clr   (en_clr),
    .cfg_q    (cfg_q),
    .active   (out_active),
    .cfg_hit  (cfg_hit)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chan
    logic sel_tick;

    assign cfg_src_q[i*SRC_W +: SRC_W]    = cfg_q[i].src;
    assign cfg_pres_q[i*PRES_W +: PRES_W] = cfg_q[i].pres;

    clkout_srcmux #(.NUM_SRC(NUM_SRC)) u_mux (
      .src_tick (src_tick),
      .sel      (cfg_q[i].src),
      .sel_tick (sel_tick)
    );

    clkout_divider #(.MAX_EXP(MAX_EXP)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (out_active[i]),
      .sel_tick (sel_tick),
      .kill     (cfg_hit[i] | en_clr[i]),
      .pres     (cfg_q[i].pres),
      .tick     (out_tick[i]),
      .ready    (out_ready[i])
    );
  end

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk #(
  parameter int NUM_OUT = 2,
  parameter int NUM_SRC = 5,
  parameter int IDX_W   = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic [IDX_W-1:0]         cfg_idx,
  input logic [NUM_OUT-1:0]       en_set,
  input logic [NUM_OUT-1:0]       en_clr,
  input logic [NUM_OUT*3-1:0]     cfg_src_q,
  input logic [NUM_OUT-1:0]       out_active,
  input logic [NUM_OUT-1:0]       out_ready,
  input logic [NUM_OUT-1:0]       out_tick
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
    // R2
    set_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_set[i]) && !$past(en_clr[i])) |-> out_active[i]);
    // R3
    clear_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_clr[i]) |-> (!out_active[i] && !out_ready[i]));
    // R8
    ready_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready[i] |-> out_active[i]);
    // R8
    write_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_we && (cfg_idx == IDX_W'(i))) |-> !out_ready[i]);
    // R7
    reserved_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick[i] |-> ($past(int'(cfg_src_q[i*3 +: 3])) < NUM_SRC));
    // R11
    tick_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick[i] |-> $past(out_active[i]));
  end
endmodule

bind clkout_gen clkout_gen_chk #(.NUM_OUT(NUM_OUT), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_idx    (cfg_idx),
  .en_set     (en_set),
  .en_clr     (en_clr),
  .cfg_src_q  (cfg_src_q),
  .out_active (out_active),
  .out_ready  (out_ready),
  .out_tick   (out_tick)
);

// File: tb/clkout_gen_bench.sv
module clkout_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_tick = '0;
  logic       cfg_we = 1'b0;
  logic [0:0] cfg_idx = '0;
  logic [2:0] cfg_src = '0;
  logic [2:0] cfg_pres = '0;
  logic [1:0] en_set = '0;
  logic [1:0] en_clr = '0;
  logic [5:0] cfg_src_q;
  logic [5:0] cfg_pres_q;
  logic [1:0] out_active;
  logic [1:0] out_ready;
  logic [1:0] out_tick;

  int n_chk = 0;
  int n_bad = 0;
  int pc0 = 0;
  int pc1 = 0;
  int base0;
  int base1;

  always #10 clk = ~clk;

  clkout_gen u_clkout_gen (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_src(cfg_src), .cfg_pres(cfg_pres),
    .en_set(en_set), .en_clr(en_clr), .cfg_src_q(cfg_src_q),
    .cfg_pres_q(cfg_pres_q), .out_active(out_active),
    .out_ready(out_ready), .out_tick(out_tick)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_tick[0]) pc0 = pc0 + 1;
      if (out_tick[1]) pc1 = pc1 + 1;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_cfg(int idx, int src, int pres);
    cfg_we = 1'b1; cfg_idx = 1'(idx); cfg_src = 3'(src); cfg_pres = 3'(pres);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_en(logic [1:0] s, logic [1:0] c);
    en_set = s; en_clr = c;
    step();
    en_set = '0; en_clr = '0;
  endtask

  task automatic ticks(logic [4:0] mask, int n);
    for (int k = 0; k < n; k++) begin
      src_tick = mask;
      step();
      src_tick = '0;
      step();
    end
  endtask

  task automatic mark();
    base0 = pc0; base1 = pc1;
  endtask

  task automatic t_reset();
    check("R1 active", out_active, 0);
    check("R1 ready", out_ready, 0);
    check("R1 tick", out_tick, 0);
    check("R1 src readback", cfg_src_q, 0);
    check("R1 pres readback", cfg_pres_q, 0);
  endtask

  task automatic t_enable_div1();
    put_cfg(0, 4, 0);
    pulse_en(2'b01, 2'b00);
    check("R2 enable out0", out_active, 1);
    pulse_en(2'b00, 2'b00);
    check("R2 zero bits no effect", out_active, 1);
    mark();
    ticks(5'b10000, 5);
    check("R5 div1 pulses", pc0 - base0, 5);
    check("R8 ready after pulse", out_ready, 1);
    check("R10 idle out1 pulses", pc1 - base1, 0);
  endtask

  task automatic t_div8();
    pulse_en(2'b00, 2'b01);
    put_cfg(0, 0, 3);
    pulse_en(2'b01, 2'b00);
    mark();
    ticks(5'b00001, 7);
    check("R5 div8 before 8th", pc0 - base0, 0);
    check("R8 not ready yet", out_ready[0], 0);
    ticks(5'b00001, 1);
    check("R5 div8 first pulse", pc0 - base0, 1);
    check("R8 ready on first pulse", out_ready[0], 1);
    ticks(5'b00001, 8);
    check("R5 div8 second pulse", pc0 - base0, 2);
  endtask

  task automatic t_code7();
    pulse_en(2'b00, 2'b01);
    put_cfg(0, 0, 7);
    check("R6 readback 7", cfg_pres_q[2:0], 7);
    pulse_en(2'b01, 2'b00);
    mark();
    ticks(5'b00001, 63);
    check("R6 code7 before 64th", pc0 - base0, 0);
    ticks(5'b00001, 1);
    check("R6 code7 at 64th", pc0 - base0, 1);
  endtask

  task automatic t_source_map();
    pulse_en(2'b00, 2'b11);
    put_cfg(1, 1, 0);
    pulse_en(2'b10, 2'b00);
    mark();
    ticks(5'b11101, 4);
    check("R4 unselected sources ignored", pc1 - base1, 0);
    ticks(5'b00010, 3);
    check("R4 main source counted", pc1 - base1, 3);
    check("R10 out0 src kept", cfg_src_q[2:0], 0);
    check("R10 out0 pres kept", cfg_pres_q[2:0], 7);
  endtask

  task automatic t_reserved();
    pulse_en(2'b00, 2'b11);
    put_cfg(0, 5, 0);
    pulse_en(2'b01, 2'b00);
    mark();
    ticks(5'b11111, 10);
    check("R7 code5 silent", pc0 - base0, 0);
    put_cfg(0, 7, 0);
    ticks(5'b11111, 10);
    check("R7 code7 silent", pc0 - base0, 0);
    check("R7 ready stays low", out_ready[0], 0);
  endtask

  task automatic t_ready();
    pulse_en(2'b00, 2'b11);
    put_cfg(0, 4, 0);
    pulse_en(2'b01, 2'b00);
    ticks(5'b10000, 1);
    check("R8 ready set", out_ready[0], 1);
    put_cfg(1, 2, 1);
    check("R10 other write keeps ready", out_ready[0], 1);
    check("R10 out1 src written", cfg_src_q[5:3], 2);
    check("R10 out1 pres written", cfg_pres_q[5:3], 1);
    put_cfg(0, 4, 0);
    check("R8 write drops ready", out_ready[0], 0);
    check("R9 stays active", out_active[0], 1);
    ticks(5'b10000, 1);
    check("R8 ready returns", out_ready[0], 1);
    pulse_en(2'b00, 2'b01);
    check("R8 clear drops ready", out_ready[0], 0);
    check("R3 clear disables", out_active[0], 0);
  endtask

  task automatic t_set_clr_same();
    pulse_en(2'b01, 2'b01);
    check("R3 clear wins from off", out_active[0], 0);
    pulse_en(2'b01, 2'b00);
    pulse_en(2'b01, 2'b01);
    check("R3 clear wins from on", out_active[0], 0);
  endtask

  task automatic t_midrun_write();
    pulse_en(2'b00, 2'b11);
    put_cfg(0, 0, 3);
    pulse_en(2'b01, 2'b00);
    mark();
    ticks(5'b00001, 5);
    check("R9 partial count", pc0 - base0, 0);
    put_cfg(0, 0, 1);
    ticks(5'b00001, 1);
    check("R9 overshoot completes", pc0 - base0, 1);
    ticks(5'b00001, 2);
    check("R9 new period", pc0 - base0, 2);
    check("R9 active kept", out_active[0], 1);
  endtask

  task automatic t_restart();
    pulse_en(2'b00, 2'b11);
    put_cfg(0, 0, 2);
    pulse_en(2'b01, 2'b00);
    mark();
    ticks(5'b00001, 3);
    pulse_en(2'b00, 2'b01);
    ticks(5'b00001, 4);
    check("R11 disabled silent", pc0 - base0, 0);
    pulse_en(2'b01, 2'b00);
    ticks(5'b00001, 3);
    check("R11 count restarted", pc0 - base0, 0);
    ticks(5'b00001, 1);
    check("R11 pulse after restart", pc0 - base0, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_enable_div1();
    t_div8();
    t_code7();
    t_source_map();
    t_reserved();
    t_ready();
    t_set_clr_same();
    t_midrun_write();
    t_restart();
    finish_run();
  end
endmodule